// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Walker

This block serves a storage DMA channel whose buffer is described by a table of 8-byte descriptors in system memory. Each descriptor holds a buffer address word and a size/control word. On a start command the walker latches the table base and the number of bytes the device side wants. It reads descriptors through a request/response memory port and keeps the current segment address and the bytes left in that segment. It then hands the data mover a series of transfer requests, each sized to the smaller of the device bytes still owed and the segment bytes still unused.

A walk ends in one of two ways. If the device count is met, it ends normally. If the table runs out first, it ends with an underrun status. The table runs out when a descriptor flagged as final has been used up, or when the table pointer has moved 4 KiB past the base. That 4 KiB fail-safe protects against a table that has no end marker. Descriptor decode has three special rules: the length is always even, a zero length means 64 KiB, and only bit 31 of the size word is used as a flag.

Top module: `prd_walker`

## Requirements
- R1: After reset, busy_o, done_o, table_end_o, mem_req_valid_o and xfer_valid_o are all low.
- R2: In idle, start_i latches table_base_i with bits 1:0 forced to zero, and latches dev_bytes_i. The first descriptor read is issued at that aligned base. Each later read is at the previous read address plus 8.
- R3: In a descriptor, the first returned word is the segment address and the second is the size word. The segment length is size[15:0] AND 0xFFFE. When that result is zero, the length is 65536. Size bits 30:16 have no effect.
- R4: Each transfer request presents the current segment address and a length of min(device bytes still owed, segment bytes left). After the request is acknowledged, the address moves up by that length and both counts drop by it.
- R5: A descriptor whose size word has bit 31 set is the last one. Once its segment is used up, no further descriptor is read.
- R6: The walk stops reading descriptors once the table pointer has moved 4096 or more bytes past the base, even with no last flag seen. A table of 2-byte segments with no last flag therefore yields exactly 512 reads.
- R7: done_o is high for exactly one cycle at the end of each walk, and busy_o is low in that cycle. table_end_o is 1 when the table ran out while device bytes were still owed, and is 0 otherwise. table_end_o holds its value until the next accepted start.
- R8: A start with a device count of zero ends the walk with done_o and no descriptor read.
- R9: start_i has no effect while busy_o is high.
- R10: mem_req_valid_o holds with a stable address until mem_req_ready_i is high. xfer_valid_o holds with stable address and length until xfer_ack_i is high. A memory request and a transfer request are never presented together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a walk (accepted only when idle) |
| table_base_i | input | 32 | Byte address of the descriptor table |
| dev_bytes_i | input | 32 | Bytes wanted by the device side |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle pulse at walk end |
| table_end_o | output | 1 | Last walk ended by table exhaustion (underrun) |
| mem_req_valid_o | output | 1 | Descriptor read request |
| mem_req_addr_o | output | 32 | Descriptor byte address |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_rsp_valid_i | input | 1 | Response beat valid |
| mem_rsp_data_i | input | 32 | Response word (address word first, then size word) |
| xfer_valid_o | output | 1 | Transfer request to the data mover |
| xfer_addr_o | output | 32 | Transfer start address |
| xfer_len_o | output | 17 | Transfer length in bytes |
| xfer_ack_i | input | 1 | Data mover completed the transfer |

## Verification
Each walk is compared against the transfer list that a model of the table predicts. Every walk runs under pseudo-random ready and acknowledge stalls. The bench tries these patterns:
- a table whose total exactly matches the device count, which shows that a normal finish leaves the underrun status clear;
- a device count that ends inside a segment, which exposes the min() sizing and shows that the walk stops without reading more descriptors;
- a table that is too short, which sets the underrun status;
- odd and zero length fields, which separate the even-masking rule and the 64 KiB rule;
- size words with junk upper bits, an unaligned base, a start pulse during a walk and a zero count, which show those inputs are ignored or cause no read;
- a 512-entry table with no end marker, which separates the 4 KiB fail-safe from the last flag.

// File: rtl/prd_walker_pkg.sv
package prd_walker_pkg;
  typedef enum logic [1:0] {W_IDLE, W_CHECK, W_FETCH, W_XFER} walk_state_e;
  typedef enum logic [1:0] {F_IDLE, F_REQ, F_W0, F_W1} fetch_state_e;
endpackage

// File: rtl/prd_desc_fetch.sv
module prd_desc_fetch
  import prd_walker_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [AW-1:0] addr_i,
  output logic          mem_req_valid_o,
  output logic [AW-1:0] mem_req_addr_o,
  input  logic          mem_req_ready_i,
  input  logic          mem_rsp_valid_i,
  input  logic [AW-1:0] mem_rsp_data_i,
  output logic          desc_valid_o,
  output logic [AW-1:0] desc_w0_o,
  output logic [AW-1:0] desc_w1_o
);
  fetch_state_e state_q;
  logic [AW-1:0] addr_q, w0_q, w1_q;
  logic dv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= F_IDLE;
      addr_q  <= '0;
      w0_q    <= '0;
      w1_q    <= '0;
      dv_q    <= 1'b0;
    end else begin
      dv_q <= 1'b0;
      case (state_q)
        F_IDLE: if (go_i) begin
          addr_q  <= addr_i;
          state_q <= F_REQ;
        end
        F_REQ: if (mem_req_ready_i) state_q <= F_W0;
        F_W0: if (mem_rsp_valid_i) begin
          w0_q    <= mem_rsp_data_i;
          state_q <= F_W1;
        end
        F_W1: if (mem_rsp_valid_i) begin
          w1_q    <= mem_rsp_data_i;
          dv_q    <= 1'b1;
          state_q <= F_IDLE;
        end
        default: state_q <= F_IDLE;
      endcase
    end
  end

  assign mem_req_valid_o = (state_q == F_REQ);
  assign mem_req_addr_o  = addr_q;
  assign desc_valid_o    = dv_q;
  assign desc_w0_o       = w0_q;
  assign desc_w1_o       = w1_q;
endmodule

// File: rtl/prd_desc_decode.sv
module prd_desc_decode #(
  parameter int unsigned AW       = 32,
  parameter int unsigned LEN_BITS = 16,
  localparam int unsigned SW      = LEN_BITS + 1
) (
  input  logic [AW-1:0] w0_i,
  input  logic [AW-1:0] w1_i,
  output logic [AW-1:0] seg_addr_o,
  output logic [SW-1:0] seg_len_o,
  output logic          last_o
);
  logic [LEN_BITS-1:0] raw_len;
  logic unused_bits;

  // length is always even; an all-zero field encodes the full range
  assign raw_len     = w1_i[LEN_BITS-1:0] & ~LEN_BITS'(1);
  assign seg_len_o   = (raw_len == '0) ? SW'(1) << LEN_BITS : {1'b0, raw_len};
  assign seg_addr_o  = w0_i;
  assign last_o      = w1_i[AW-1];
  assign unused_bits = ^w1_i[AW-2:LEN_BITS];
endmodule

// File: rtl/prd_xfer_size.sv
module prd_xfer_size #(
  parameter int unsigned CW = 32,
  parameter int unsigned SW = 17
) (
  input  logic [CW-1:0] rem_i,
  input  logic [SW-1:0] seg_i,
  output logic [SW-1:0] len_o
);
  logic [CW-1:0] seg_ext;
  assign seg_ext = CW'(seg_i);
  assign len_o   = (rem_i < seg_ext) ? SW'(rem_i) : seg_i;
endmodule

// File: rtl/prd_walker.sv
module prd_walker
  import prd_walker_pkg::*;
#(
  parameter int unsigned AW          = 32,
  parameter int unsigned CW          = 32,
  parameter int unsigned LEN_BITS    = 16,
  parameter int unsigned TABLE_LIMIT = 4096,
  parameter int unsigned DESC_BYTES  = 8,
  localparam int unsigned SW         = LEN_BITS + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] table_base_i,
  input  logic [CW-1:0] dev_bytes_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          table_end_o,
  output logic          mem_req_valid_o,
  output logic [AW-1:0] mem_req_addr_o,
  input  logic          mem_req_ready_i,
  input  logic          mem_rsp_valid_i,
  input  logic [AW-1:0] mem_rsp_data_i,
  output logic          xfer_valid_o,
  output logic [AW-1:0] xfer_addr_o,
  output logic [SW-1:0] xfer_len_o,
  input  logic          xfer_ack_i
);
  walk_state_e state_q;
  logic [AW-1:0] base_q, ptr_q, seg_addr_q;
  logic [CW-1:0] rem_q;
  logic [SW-1:0] seg_len_q, xlen;
  logic last_q, done_q, tend_q;

  logic          fetch_go, desc_valid, dec_last, exhausted;
  logic [AW-1:0] desc_w0, desc_w1, dec_addr, used;
  logic [SW-1:0] dec_len;

  assign used      = ptr_q - base_q;
  assign exhausted = last_q || (used >= AW'(TABLE_LIMIT));
  assign fetch_go  = (state_q == W_CHECK) && (rem_q != '0) && (seg_len_q == '0) && !exhausted;

  prd_desc_fetch #(.AW(AW)) u_fetch (
    .clk_i, .rst_ni,
    .go_i            (fetch_go),
    .addr_i          (ptr_q),
    .mem_req_valid_o,
    .mem_req_addr_o,
    .mem_req_ready_i,
    .mem_rsp_valid_i,
    .mem_rsp_data_i,
    .desc_valid_o    (desc_valid),
    .desc_w0_o       (desc_w0),
    .desc_w1_o       (desc_w1)
  );

  prd_desc_decode #(.AW(AW), .LEN_BITS(LEN_BITS)) u_dec (
    .w0_i       (desc_w0),
    .w1_i       (desc_w1),
    .seg_addr_o (dec_addr),
    .seg_len_o  (dec_len),
    .last_o     (dec_last)
  );

  prd_xfer_size #(.CW(CW), .SW(SW)) u_size (
    .rem_i (rem_q),
    .seg_i (seg_len_q),
    .len_o (xlen)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= W_IDLE;
      base_q     <= '0;
      ptr_q      <= '0;
      seg_addr_q <= '0;
      seg_len_q  <= '0;
      rem_q      <= '0;
      last_q     <= 1'b0;
      done_q     <= 1'b0;
      tend_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        W_IDLE: if (start_i) begin
          base_q     <= table_base_i & ~AW'(3);
          ptr_q      <= table_base_i & ~AW'(3);
          rem_q      <= dev_bytes_i;
          seg_addr_q <= '0;
          seg_len_q  <= '0;
          last_q     <= 1'b0;
          tend_q     <= 1'b0;
          state_q    <= W_CHECK;
        end
        W_CHECK: begin
          if (rem_q == '0) begin
            done_q  <= 1'b1;
            state_q <= W_IDLE;
          end else if (seg_len_q != '0) begin
            state_q <= W_XFER;
          end else if (exhausted) begin
            done_q  <= 1'b1;
            tend_q  <= 1'b1;
            state_q <= W_IDLE;
          end else begin
            state_q <= W_FETCH;
          end
        end
        W_FETCH: if (desc_valid) begin
          seg_addr_q <= dec_addr;
          seg_len_q  <= dec_len;
          last_q     <= dec_last;
          ptr_q      <= ptr_q + AW'(DESC_BYTES);
          state_q    <= W_CHECK;
        end
        W_XFER: if (xfer_ack_i) begin
          seg_addr_q <= seg_addr_q + AW'(xlen);
          seg_len_q  <= seg_len_q - xlen;
          rem_q      <= rem_q - CW'(xlen);
          state_q    <= W_CHECK;
        end
        default: state_q <= W_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != W_IDLE);
  assign done_o       = done_q;
  assign table_end_o  = tend_q;
  assign xfer_valid_o = (state_q == W_XFER);
  assign xfer_addr_o  = seg_addr_q;
  assign xfer_len_o   = xlen;
endmodule

// File: rtl/prd_walker_chk.sv
module prd_walker_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned SW = 17
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic          mem_req_valid_o,
  input logic [AW-1:0] mem_req_addr_o,
  input logic          mem_req_ready_i,
  input logic          xfer_valid_o,
  input logic [AW-1:0] xfer_addr_o,
  input logic [SW-1:0] xfer_len_o,
  input logic          xfer_ack_i
);
  // R1
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_valid_o && !xfer_valid_o));
  // R2
  a_r2_req_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> (mem_req_addr_o[1:0] == 2'b00));
  // R4
  a_r4_len_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o |-> ((xfer_len_o != '0) && (xfer_len_o <= (SW'(1) << (SW-1)))));
  // R7
  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R10
  a_r10_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));
  a_r10_xfer_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_valid_o && !xfer_ack_i) |=> (xfer_valid_o && $stable(xfer_addr_o) && $stable(xfer_len_o)));
  a_r10_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_valid_o && xfer_valid_o));
endmodule

bind prd_walker prd_walker_chk #(.AW(AW), .SW(SW)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .busy_o          (busy_o),
  .done_o          (done_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_addr_o  (mem_req_addr_o),
  .mem_req_ready_i (mem_req_ready_i),
  .xfer_valid_o    (xfer_valid_o),
  .xfer_addr_o     (xfer_addr_o),
  .xfer_len_o      (xfer_len_o),
  .xfer_ack_i      (xfer_ack_i)
);

// File: tb/prd_walker_test.sv
module prd_walker_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, start;
  logic [31:0] base, dev;
  logic        busy, done, tend, mreq_v, mready, mrsp_v, xv, xack;
  logic [31:0] maddr, mdata, xaddr;
  logic [16:0] xlen;

  prd_walker uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .table_base_i(base), .dev_bytes_i(dev),
    .busy_o(busy), .done_o(done), .table_end_o(tend),
    .mem_req_valid_o(mreq_v), .mem_req_addr_o(maddr), .mem_req_ready_i(mready),
    .mem_rsp_valid_i(mrsp_v), .mem_rsp_data_i(mdata),
    .xfer_valid_o(xv), .xfer_addr_o(xaddr), .xfer_len_o(xlen), .xfer_ack_i(xack)
  );

  // memory model and stall generator
  logic [31:0] mem [0:2047];
  logic [15:0] lfsr = 16'hACE1;
  int          rbeats = 0;
  logic [10:0] ridx = '0;
  always @(posedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  assign mready = lfsr[0] | lfsr[3];
  assign xack   = lfsr[5] | lfsr[1];

  initial begin mrsp_v = 1'b0; mdata = '0; end
  always @(posedge clk) begin
    if (rbeats != 0) begin
      mrsp_v <= 1'b1;
      mdata  <= mem[ridx + 11'(2 - rbeats)];
      rbeats <= rbeats - 1;
    end else mrsp_v <= 1'b0;
    if (mreq_v && mready) begin
      rbeats <= 2;
      ridx   <= maddr[12:2];
    end
  end

  // monitor
  logic [31:0] got_addr [0:599];
  logic [16:0] got_len  [0:599];
  int   n_x = 0, n_f = 0, n_d = 0;
  logic [31:0] first_f = '0;
  logic mon_clr = 1'b0;
  always @(posedge clk) begin
    if (mon_clr) begin
      n_x <= 0; n_f <= 0; n_d <= 0;
    end else begin
      if (xv && xack && n_x < 600) begin
        got_addr[n_x] <= xaddr;
        got_len[n_x]  <= xlen;
        n_x <= n_x + 1;
      end
      if (mreq_v && mready) begin
        if (n_f == 0) first_f <= maddr;
        n_f <= n_f + 1;
      end
      if (done) n_d <= n_d + 1;
    end
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [31:0] base;
    logic [31:0] dev;
    logic [15:0] n;
    logic [15:0] len0;
    logic [15:0] step;
    logic [15:0] last_idx;
    logic        junk;
    logic        poke;
  } scen_t;

  localparam int NS = 7;
  localparam scen_t SCEN [NS] = '{
    '{32'h0100, 32'h0300,  16'd3,   16'h0100, 16'h0000, 16'd2,     1'b0, 1'b1}, // R4 R9 exact fit, start poke
    '{32'h0200, 32'h0150,  16'd3,   16'h0100, 16'h0000, 16'd2,     1'b1, 1'b0}, // R3 R4 split segment, junk bits
    '{32'h0400, 32'h1000,  16'd2,   16'h0101, 16'h0010, 16'd1,     1'b0, 1'b0}, // R3 R5 odd length, underrun
    '{32'h0603, 32'h20000, 16'd2,   16'h0000, 16'h0000, 16'd1,     1'b0, 1'b0}, // R2 R3 zero=64K, unaligned base
    '{32'h0700, 32'h0000,  16'd1,   16'h0100, 16'h0000, 16'd0,     1'b0, 1'b0}, // R8 zero count
    '{32'h0780, 32'h10000, 16'd1,   16'h0001, 16'h0000, 16'd0,     1'b0, 1'b0}, // R3 length 1 -> 64K
    '{32'h0000, 32'h10000, 16'd512, 16'h0002, 16'h0000, 16'hFFFF, 1'b0, 1'b0}  // R6 fail-safe
  };

  logic [31:0] exp_addr [0:599];
  logic [16:0] exp_len  [0:599];
  int          exp_x, exp_f;
  bit          exp_tend;

  task automatic build(input int k, input scen_t s);
    logic [31:0] b, rem, sz, da;
    logic [16:0] l, x;
    int i;
    bit fin, lastf;
    b = s.base & ~32'h3;
    for (int j = 0; j < int'(s.n); j++) begin
      da = 32'h1000_0000 + (32'(k) << 20) + 32'(j) * 32'h0002_0000;
      sz = {(j == int'(s.last_idx)), (s.junk ? 15'h7ABC : 15'h0), 16'(s.len0 + 16'(j) * s.step)};
      mem[b[12:2] + 11'(2*j)]     = da;
      mem[b[12:2] + 11'(2*j + 1)] = sz;
    end
    rem = s.dev; exp_x = 0; exp_f = 0; exp_tend = 0; i = 0; fin = 0; lastf = 0;
    while (!fin) begin
      if (rem == 0) fin = 1;
      else if (lastf || i >= 512) begin exp_tend = 1; fin = 1; end
      else begin
        da = mem[b[12:2] + 11'(2*i)];
        sz = mem[b[12:2] + 11'(2*i + 1)];
        l  = {1'b0, sz[15:0] & 16'hFFFE};
        if (l == 0) l = 17'h10000;
        x = (rem < 32'(l)) ? 17'(rem) : l;
        exp_addr[exp_x] = da;
        exp_len[exp_x]  = x;
        exp_x++; exp_f++;
        rem = rem - 32'(x);
        lastf = sz[31];
        i++;
      end
    end
  endtask

  task automatic run(input int k);
    scen_t s;
    int w;
    s = SCEN[k];
    build(k, s);
    @(negedge clk); mon_clr = 1'b1;
    @(negedge clk); mon_clr = 1'b0;
    base = s.base; dev = s.dev; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(tend == 1'b0, $sformatf("R7 table_end cleared by start row %0d", k), 64'(tend), 0);
    if (s.poke) begin
      repeat (3) @(negedge clk);
      base = 32'h1F00; dev = 32'h4; start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    w = 0;
    while (n_d == 0 && w < 60000) begin @(negedge clk); w++; end
    chk(w < 60000, $sformatf("R7 walk end row %0d", k), 64'(w), 0);
    repeat (3) @(negedge clk);
    chk(n_d == 1, $sformatf("R7 one done pulse row %0d", k), 64'(n_d), 1);
    chk(!busy, $sformatf("R7 idle after done row %0d", k), 64'(busy), 0);
    chk(tend == exp_tend, $sformatf("R5 R6 R7 table_end row %0d", k), 64'(tend), 64'(exp_tend));
    chk(n_f == exp_f, $sformatf("R5 R6 R8 fetch count row %0d", k), 64'(n_f), 64'(exp_f));
    if (exp_f > 0)
      chk(first_f == (s.base & ~32'h3), $sformatf("R2 first fetch addr row %0d", k), 64'(first_f), 64'(s.base & ~32'h3));
    chk(n_x == exp_x, $sformatf("R4 transfer count row %0d", k), 64'(n_x), 64'(exp_x));
    for (int j = 0; j < exp_x && j < n_x; j++) begin
      if (got_addr[j] != exp_addr[j] || got_len[j] != exp_len[j]) begin
        chk(1'b0, $sformatf("R3 R4 transfer %0d row %0d", j, k),
            {got_addr[j], 15'b0, got_len[j]}, {exp_addr[j], 15'b0, exp_len[j]});
      end else n_chk++;
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; base = '0; dev = '0;
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy, "R1 busy", 64'(busy), 0);
    chk(!done, "R1 done", 64'(done), 0);
    chk(!tend, "R1 table_end", 64'(tend), 0);
    chk(!mreq_v, "R1 mem_req_valid", 64'(mreq_v), 0);
    chk(!xv, "R1 xfer_valid", 64'(xv), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int k = 0; k < NS; k++) run(k);
    // R7: underrun status persists while idle
    run(2);
    repeat (5) @(negedge clk);
    chk(tend == 1'b1, "R7 table_end held in idle", 64'(tend), 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule